// File: doc/BRIEF.md
# Funnel Shift Left Unit

This execution unit carries out a left funnel shift on a pair of 32-bit words and returns only the upper word of the result. The two source words are treated as one double-width value, with the high operand on top and the low operand below. That value is shifted left, so bits from the top of the low operand move up into the returned word. The shift count comes either from a register operand or from a 6-bit immediate carried in the instruction word. The instruction word also chooses the operand size (a 32-bit or a 64-bit pair) and whether the count wraps or is clamped.

Before the shift, the count is conditioned. Wrap mode keeps the count modulo the operand size. Clamp mode reads the register count as a signed number and limits it to the range from zero up to the operand size. Two operating variants are not supported: the extended shift modes and condition-code generation. If either is requested, the unit raises an illegal-operation flag. The result and the flag come out one clock after the inputs, both registered.

Top module: `fshl_unit`

## Requirements
- R1: The operand-size field is instr[38:37]. Code 0 selects a 32-bit size. Codes 1, 2 and 3 all select a 64-bit size, so the signed and unsigned 64-bit codes behave the same.
- R2: The other instruction-word fields are: extended mode at instr[49:48], the wrap flag at instr[50], and the 6-bit immediate count at instr[25:20]. No other instruction bit affects the outputs.
- R3: When imm_sel is 1, the zero-extended immediate is used as the count and reg_amt has no effect. When imm_sel is 0, reg_amt is used. This choice is made before wrap or clamp is applied.
- R4: When the wrap flag is 1, the effective count is the raw count ANDed with (size - 1). This gives 0..31 for the 32-bit size and 0..63 for the 64-bit size.
- R5: When the wrap flag is 0, the raw count is read as signed. A negative count gives 0, and a count above the size gives the size.
- R6: For the 32-bit size with effective count s (0..32), the result is (src_hi << s) | (src_lo >> (32 - s)). Each partial shift is 0 when its own count is 32. So s = 0 returns src_hi and s = 32 returns src_lo.
- R7: For the 64-bit size, the result depends on the effective count s:
  - s = 0 returns src_hi.
  - 0 < s < 32 returns (src_lo >> (32 - s)) | (src_hi << s).
  - s >= 32 returns src_lo << (s - 32).
  - s = 64 returns 0.
- R8: illegal is 1 exactly when the extended-mode field is nonzero or cc_req is 1. In that case the result is don't-care.
- R9: result and illegal are registered and appear one rising edge after the inputs. A synchronous active-high rst clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 64 | Instruction word carrying the size, extended-mode, wrap and immediate fields |
| cc_req | input | 1 | Condition-code generation request (unsupported) |
| imm_sel | input | 1 | 1 selects the immediate count, 0 selects reg_amt |
| src_lo | input | 32 | Low operand of the pair |
| src_hi | input | 32 | High operand of the pair |
| reg_amt | input | 32 | Register shift count, signed when clamped |
| result | output | 32 | Upper word of the shifted pair |
| illegal | output | 1 | Unsupported-operation flag |

## Verification
The bound checker watches these properties on every cycle:
- the illegal flag against the registered extended-mode field and condition-code request;
- the reset clear;
- the fixed-outcome corners: a negative clamped count returning the high word, a clamped 32-bit count of 32 or more returning the low word, a saturated 64-bit count giving zero, and a wrapped 32-bit immediate of 32 falling back to the high word.

Everything else is shown only by the bench's scenarios, which compare each output against a double-width shift model:
- the blended bits for intermediate counts (1, 31, 33, 63);
- wrap arithmetic on large and negative register counts;
- the immediate masking of the register count;
- the equivalence of the size codes;
- the one-edge latency.

// File: rtl/fshl_pkg.sv
package fshl_pkg;

   localparam int FSH_IMM_W = 6;

   typedef enum logic [1:0] {
      FSH_W32  = 2'd0,
      FSH_RSVD = 2'd1,
      FSH_U64  = 2'd2,
      FSH_S64  = 2'd3
   } fsh_kind_e;

   typedef struct packed {
      fsh_kind_e              kind;
      logic [1:0]             ext_mode;
      logic                   wrap;
      logic [FSH_IMM_W-1:0]   imm;
   } fsh_ctl_t;

   function automatic logic kind_is_wide(input fsh_kind_e k);
      return k != FSH_W32;
   endfunction

endpackage

// File: rtl/fshl_decode.sv
module fshl_decode
   import fshl_pkg::*;
#(
   parameter int INSTR_W  = 64,
   parameter int KIND_LSB = 37,
   parameter int EXT_LSB  = 48,
   parameter int WRAP_BIT = 50,
   parameter int IMM_LSB  = 20
) (
   input  logic [INSTR_W-1:0] instr,
   output fsh_ctl_t           ctl
);

   if (KIND_LSB + 2 > INSTR_W) begin : g_bad_kind
      $error("fshl_decode: size field outside instruction word");
   end
   if (EXT_LSB + 2 > INSTR_W) begin : g_bad_ext
      $error("fshl_decode: extended-mode field outside instruction word");
   end
   if (WRAP_BIT >= INSTR_W) begin : g_bad_wrap
      $error("fshl_decode: wrap bit outside instruction word");
   end
   if (IMM_LSB + FSH_IMM_W > INSTR_W) begin : g_bad_imm
      $error("fshl_decode: immediate field outside instruction word");
   end

   logic [INSTR_W-1:0] unused_instr;

   always_comb begin
      ctl.kind     = fsh_kind_e'(instr[KIND_LSB +: 2]);
      ctl.ext_mode = instr[EXT_LSB +: 2];
      ctl.wrap     = instr[WRAP_BIT];
      ctl.imm      = instr[IMM_LSB +: FSH_IMM_W];
   end

   assign unused_instr = instr;

endmodule

// File: rtl/fshl_amount.sv
module fshl_amount #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 6,
   parameter int SH_W   = $clog2(2*DATA_W) + 1
) (
   input  logic              imm_sel,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] reg_amt,
   input  logic              wrap,
   input  logic              wide,
   output logic [SH_W-1:0]   shamt
);

   localparam int RW = DATA_W + 1;
   localparam logic [SH_W-1:0] SZ_NARROW = SH_W'(DATA_W);
   localparam logic [SH_W-1:0] SZ_WIDE   = SH_W'(2*DATA_W);
   localparam logic [SH_W-1:0] ONE_S     = SH_W'(1);

   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("fshl_amount: immediate wider than data path");
   end
   if (SH_W >= RW) begin : g_bad_sh
      $error("fshl_amount: count width must be narrower than data path");
   end

   logic signed [RW-1:0] raw;
   logic signed [RW-1:0] size_raw;
   logic [SH_W-1:0]      size_s;
   logic [SH_W-1:0]      wrapped;
   logic [SH_W-1:0]      clamped;

   always_comb begin
      if (imm_sel) raw = {{(RW-IMM_W){1'b0}}, imm};
      else         raw = {reg_amt[DATA_W-1], reg_amt};
   end

   assign size_s   = wide ? SZ_WIDE : SZ_NARROW;
   assign size_raw = {{(RW-SH_W){1'b0}}, size_s};
   assign wrapped  = raw[SH_W-1:0] & (size_s - ONE_S);

   always_comb begin
      if (raw[RW-1])            clamped = '0;
      else if (raw > size_raw)  clamped = size_s;
      else                      clamped = raw[SH_W-1:0];
   end

   assign shamt = wrap ? wrapped : clamped;

endmodule

// File: rtl/fshl_datapath.sv
module fshl_datapath #(
   parameter int DATA_W    = 32,
   parameter int SH_W      = $clog2(2*DATA_W) + 1,
   parameter int PAIR_IMPL = 0
) (
   input  logic [DATA_W-1:0] src_lo,
   input  logic [DATA_W-1:0] src_hi,
   input  logic [SH_W-1:0]   shamt,
   input  logic              wide,
   output logic [DATA_W-1:0] res
);

   localparam logic [SH_W-1:0] DW_S = SH_W'(DATA_W);

   if (PAIR_IMPL != 0 && PAIR_IMPL != 1) begin : g_bad_impl
      $error("fshl_datapath: PAIR_IMPL must be 0 or 1");
   end

   if (PAIR_IMPL == 0) begin : g_split
      logic [SH_W-1:0]   lo_cnt;
      logic [SH_W-1:0]   red_cnt;
      logic [DATA_W-1:0] hi_part;
      logic [DATA_W-1:0] lo_part;
      logic [DATA_W-1:0] blend;
      logic [DATA_W-1:0] upper;

      assign lo_cnt  = DW_S - shamt;
      assign red_cnt = shamt - DW_S;

      always_comb begin
         hi_part = (shamt  == DW_S) ? '0 : (src_hi << shamt);
         lo_part = (lo_cnt == DW_S) ? '0 : (src_lo >> lo_cnt);
         blend   = hi_part | lo_part;
         upper   = (red_cnt == DW_S) ? '0 : (src_lo << red_cnt);
      end

      always_comb begin
         if (!wide)               res = blend;
         else if (shamt == '0)    res = src_hi;
         else if (shamt < DW_S)   res = blend;
         else                     res = upper;
      end
   end else begin : g_unified
      logic [2*DATA_W-1:0] pair;
      logic                unused_wide;

      assign unused_wide = wide;
      assign pair        = {src_hi, src_lo} << shamt;
      assign res         = pair[2*DATA_W-1:DATA_W];
   end

endmodule

// File: rtl/fshl_unit.sv
module fshl_unit
   import fshl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int INSTR_W   = 64,
   parameter int KIND_LSB  = 37,
   parameter int EXT_LSB   = 48,
   parameter int WRAP_BIT  = 50,
   parameter int IMM_LSB   = 20,
   parameter int PAIR_IMPL = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic               cc_req,
   input  logic               imm_sel,
   input  logic [DATA_W-1:0]  src_lo,
   input  logic [DATA_W-1:0]  src_hi,
   input  logic [DATA_W-1:0]  reg_amt,
   output logic [DATA_W-1:0]  result,
   output logic               illegal
);

   localparam int SH_W = $clog2(2*DATA_W) + 1;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("fshl_unit: DATA_W must be a power of two of at least 8");
   end

   fsh_ctl_t          ctl;
   logic              wide;
   logic [SH_W-1:0]   shamt;
   logic [DATA_W-1:0] res_c;
   logic              illegal_c;

   fshl_decode #(
      .INSTR_W  (INSTR_W),
      .KIND_LSB (KIND_LSB),
      .EXT_LSB  (EXT_LSB),
      .WRAP_BIT (WRAP_BIT),
      .IMM_LSB  (IMM_LSB)
   ) u_dec (
      .instr (instr),
      .ctl   (ctl)
   );

   assign wide      = kind_is_wide(ctl.kind);
   assign illegal_c = (ctl.ext_mode != 2'd0) | cc_req;

   fshl_amount #(
      .DATA_W (DATA_W),
      .IMM_W  (FSH_IMM_W),
      .SH_W   (SH_W)
   ) u_amt (
      .imm_sel (imm_sel),
      .imm     (ctl.imm),
      .reg_amt (reg_amt),
      .wrap    (ctl.wrap),
      .wide    (wide),
      .shamt   (shamt)
   );

   fshl_datapath #(
      .DATA_W    (DATA_W),
      .SH_W      (SH_W),
      .PAIR_IMPL (PAIR_IMPL)
   ) u_dp (
      .src_lo (src_lo),
      .src_hi (src_hi),
      .shamt  (shamt),
      .wide   (wide),
      .res    (res_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result  <= '0;
         illegal <= 1'b0;
      end else begin
         result  <= res_c;
         illegal <= illegal_c;
      end
   end

endmodule

// File: rtl/fshl_unit_chk.sv
module fshl_unit_chk #(
   parameter int DATA_W   = 32,
   parameter int INSTR_W  = 64,
   parameter int KIND_LSB = 37,
   parameter int EXT_LSB  = 48,
   parameter int WRAP_BIT = 50,
   parameter int IMM_LSB  = 20
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr,
   input logic               cc_req,
   input logic               imm_sel,
   input logic [DATA_W-1:0]  src_lo,
   input logic [DATA_W-1:0]  src_hi,
   input logic [DATA_W-1:0]  reg_amt,
   input logic [DATA_W-1:0]  result,
   input logic               illegal
);

   localparam logic [DATA_W-1:0] N_ONE = DATA_W'(DATA_W);
   localparam logic [DATA_W-1:0] N_TWO = DATA_W'(2*DATA_W);

   logic       armed = 1'b0;
   logic       rst_d = 1'b0;
   logic [1:0] kind_f;
   logic [1:0] ext_f;
   logic       wrap_f;
   logic [5:0] imm_f;

   assign kind_f = instr[KIND_LSB +: 2];
   assign ext_f  = instr[EXT_LSB +: 2];
   assign wrap_f = instr[WRAP_BIT];
   assign imm_f  = instr[IMM_LSB +: 6];

   always_ff @(posedge clk) begin
      armed <= !rst;
      rst_d <= rst;
   end

   // R9: reset leaves both outputs cleared
   a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (result == '0 && !illegal));

   // R8: flag follows unsupported requests one edge later
   a_r8_illegal_flag: assert property (@(posedge clk) disable iff (rst)
      armed |-> (illegal == $past(ext_f != 2'd0 || cc_req)));

   // R5: a negative clamped count returns the high word
   a_r5_negative_clamp: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(!imm_sel && !wrap_f && reg_amt[DATA_W-1]))
         |-> (result == $past(src_hi)));

   // R6: 32-bit clamp at full size returns the low word
   a_r6_narrow_full: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(kind_f == 2'd0 && !wrap_f && !imm_sel &&
                      !reg_amt[DATA_W-1] && reg_amt >= N_ONE))
         |-> (result == $past(src_lo)));

   // R7: 64-bit clamp at full size gives zero
   a_r7_wide_saturated: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(kind_f != 2'd0 && !wrap_f && !imm_sel &&
                      !reg_amt[DATA_W-1] && reg_amt >= N_TWO))
         |-> (result == '0));

   // R4: a wrapped 32-bit immediate of 32 reduces to zero
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(kind_f == 2'd0 && wrap_f && imm_sel && imm_f == 6'd32))
         |-> (result == $past(src_hi)));

endmodule

bind fshl_unit fshl_unit_chk #(
   .DATA_W   (DATA_W),
   .INSTR_W  (INSTR_W),
   .KIND_LSB (KIND_LSB),
   .EXT_LSB  (EXT_LSB),
   .WRAP_BIT (WRAP_BIT),
   .IMM_LSB  (IMM_LSB)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .instr   (instr),
   .cc_req  (cc_req),
   .imm_sel (imm_sel),
   .src_lo  (src_lo),
   .src_hi  (src_hi),
   .reg_amt (reg_amt),
   .result  (result),
   .illegal (illegal)
);

// File: tb/fshl_unit_test.sv
module fshl_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] instr = '0;
   logic        cc_req = 1'b0;
   logic        imm_sel = 1'b0;
   logic [31:0] src_lo = '0;
   logic [31:0] src_hi = '0;
   logic [31:0] reg_amt = '0;
   logic [31:0] result;
   logic        illegal;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   fshl_unit uut (
      .clk     (clk),
      .rst     (rst),
      .instr   (instr),
      .cc_req  (cc_req),
      .imm_sel (imm_sel),
      .src_lo  (src_lo),
      .src_hi  (src_hi),
      .reg_amt (reg_amt),
      .result  (result),
      .illegal (illegal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] mk_instr(input logic [1:0] kind, input logic [1:0] ext,
                                            input logic wrap, input logic [5:0] imm,
                                            input logic [63:0] fill);
      logic [63:0] w;
      w        = fill;
      w[38:37] = kind;
      w[49:48] = ext;
      w[50]    = wrap;
      w[25:20] = imm;
      return w;
   endfunction

   function automatic logic [31:0] model(input logic [1:0] kind, input logic wrap,
                                         input logic isel, input logic [5:0] imm,
                                         input logic [31:0] lo, input logic [31:0] hi,
                                         input logic [31:0] rv);
      longint      raw;
      longint      size;
      longint      s;
      logic [63:0] pair;
      size = (kind == 2'd0) ? 32 : 64;
      raw  = isel ? longint'(imm) : longint'($signed(rv));
      if (wrap)             s = raw & (size - 1);
      else if (raw < 0)     s = 0;
      else if (raw > size)  s = size;
      else                  s = raw;
      pair = {hi, lo} << s;
      return pair[63:32];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [1:0] kind, input logic [1:0] ext,
                      input logic wrap, input logic [5:0] imm, input logic isel,
                      input logic cc, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [31:0] rv, input logic [63:0] fill);
      logic [31:0] exp;
      @(negedge clk);
      instr   = mk_instr(kind, ext, wrap, imm, fill);
      cc_req  = cc;
      imm_sel = isel;
      src_lo  = lo;
      src_hi  = hi;
      reg_amt = rv;
      exp     = model(kind, wrap, isel, imm, lo, hi, rv);
      @(posedge clk);
      @(negedge clk);
      check({tag, " illegal"}, {31'd0, illegal}, {31'd0, (ext != 2'd0) || cc});
      if (ext == 2'd0 && !cc) check(tag, result, exp);
   endtask

   localparam logic [63:0] FILL_A = 64'h0;
   localparam logic [63:0] FILL_B = 64'hFFFF_FFFF_FFFF_FFFF;

   task automatic t_reset;
      rst = 1'b1;
      @(negedge clk);
      src_hi  = 32'hFFFF_FFFF;
      reg_amt = 32'd5;
      @(posedge clk);
      @(negedge clk);
      check("R9 reset result", result, 32'h0);
      check("R9 reset illegal", {31'd0, illegal}, 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_narrow_clamp;
      int amts[8] = '{0, 1, 31, 32, 33, -1, -100, 32'h7FFF_FFFF};
      foreach (amts[i])
         run("R6/R5 narrow clamp", 2'd0, 2'd0, 1'b0, 6'd0, 1'b0, 1'b0,
             32'h89AB_CDEF, 32'h1357_9BDF, 32'(amts[i]), FILL_A);
   endtask

   task automatic t_wide_clamp;
      int amts[10] = '{0, 1, 31, 32, 33, 63, 64, 65, -5, 32'h8000_0000};
      foreach (amts[i])
         run("R7/R5 wide clamp", 2'd2, 2'd0, 1'b0, 6'd0, 1'b0, 1'b0,
             32'hF0E1_D2C3, 32'h2468_ACE0, 32'(amts[i]), FILL_A);
   endtask

   task automatic t_wrap;
      int amts[6] = '{33, 32, -1, 64, 100, 31};
      foreach (amts[i]) begin
         run("R4 wrap narrow", 2'd0, 2'd0, 1'b1, 6'd0, 1'b0, 1'b0,
             32'hDEAD_BEEF, 32'hCAFE_F00D, 32'(amts[i]), FILL_A);
         run("R4 wrap wide", 2'd3, 2'd0, 1'b1, 6'd0, 1'b0, 1'b0,
             32'hDEAD_BEEF, 32'hCAFE_F00D, 32'(amts[i]), FILL_A);
      end
   endtask

   task automatic t_immediate;
      int imms[6] = '{0, 1, 31, 32, 33, 63};
      foreach (imms[i]) begin
         run("R3 imm narrow clamp", 2'd0, 2'd0, 1'b0, 6'(imms[i]), 1'b1, 1'b0,
             32'h0F1E_2D3C, 32'hA5A5_5A5A, 32'hFFFF_FFF0, FILL_A);
         run("R3 imm wide clamp", 2'd2, 2'd0, 1'b0, 6'(imms[i]), 1'b1, 1'b0,
             32'h0F1E_2D3C, 32'hA5A5_5A5A, 32'd7, FILL_A);
         run("R3 imm narrow wrap", 2'd0, 2'd0, 1'b1, 6'(imms[i]), 1'b1, 1'b0,
             32'h0F1E_2D3C, 32'hA5A5_5A5A, 32'd9, FILL_A);
      end
   endtask

   task automatic t_kinds_and_fields;
      run("R1 kind1 wide", 2'd1, 2'd0, 1'b0, 6'd0, 1'b0, 1'b0,
          32'h1234_5678, 32'h9ABC_DEF0, 32'd40, FILL_A);
      run("R1 kind3 wide", 2'd3, 2'd0, 1'b0, 6'd0, 1'b0, 1'b0,
          32'h1234_5678, 32'h9ABC_DEF0, 32'd40, FILL_A);
      run("R1 kind0 narrow", 2'd0, 2'd0, 1'b0, 6'd0, 1'b0, 1'b0,
          32'h1234_5678, 32'h9ABC_DEF0, 32'd40, FILL_A);
      run("R2 other bits set", 2'd2, 2'd0, 1'b0, 6'd12, 1'b1, 1'b0,
          32'h1234_5678, 32'h9ABC_DEF0, 32'd0, FILL_B);
      run("R2 other bits set narrow", 2'd0, 2'd0, 1'b1, 6'd45, 1'b1, 1'b0,
          32'h1234_5678, 32'h9ABC_DEF0, 32'd0, FILL_B);
   endtask

   task automatic t_illegal;
      run("R8 ext mode 1", 2'd0, 2'd1, 1'b0, 6'd3, 1'b1, 1'b0,
          32'h1, 32'h2, 32'd0, FILL_A);
      run("R8 ext mode 3", 2'd2, 2'd3, 1'b0, 6'd3, 1'b1, 1'b0,
          32'h1, 32'h2, 32'd0, FILL_A);
      run("R8 cc request", 2'd0, 2'd0, 1'b0, 6'd3, 1'b1, 1'b1,
          32'h1, 32'h2, 32'd0, FILL_A);
      run("R8 legal again", 2'd0, 2'd0, 1'b0, 6'd3, 1'b1, 1'b0,
          32'h1, 32'h2, 32'd0, FILL_A);
   endtask

   task automatic t_latency;
      run("R9 latency first", 2'd0, 2'd0, 1'b0, 6'd4, 1'b1, 1'b0,
          32'h0, 32'h0000_00FF, 32'd0, FILL_A);
      @(negedge clk);
      src_hi = 32'h0000_0001;
      #1;
      check("R9 held before edge", result, 32'h0000_0FF0);
      @(posedge clk);
      @(negedge clk);
      check("R9 updated after edge", result, 32'h0000_0010);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_narrow_clamp();
      t_wide_clamp();
      t_wrap();
      t_immediate();
      t_kinds_and_fields();
      t_illegal();
      t_latency();
      t_reset();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule